// File: doc/BRIEF.md
# EEPROM Write-Completion Poller

After a host has issued a byte or page write to a byte-wide parallel EEPROM, the array programs itself for up to about 10 ms. This engine takes the address and data of the last byte written and works out when that internal write has finished. It does this with ordinary read cycles, not with a ready pin and not by waiting a fixed worst-case time. A mode bit chooses the method. In data mode, the engine reads back the saved address until bit 7 matches the bit 7 that was written. It then makes one more read, and that read must return the whole byte. In toggle mode, the engine reads until two reads in a row return the same bit 6.

Every poll is a separate read access. Chip enable and output enable are held low for a set number of clocks, the byte is sampled at the end, and both strobes are then released for a gap before the next access. If no completion is seen within the deadline, the engine stops and flags a timeout. After a completion, it stays busy for a guard interval so that the next write cannot start too early. A start pulse is accepted only when the engine is idle. No data stream crosses the block's edge, so every pin is a plain control or status signal.

Top module: `epoll_poller`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done`, `timeout` and `poll_count` are 0, and `mem_ce_n`, `mem_oe_n` and `mem_we_n` are all 1.
- R2: Each poll is a read cycle. `mem_ce_n` and `mem_oe_n` go low together for exactly OE_WAIT clocks while `mem_we_n` stays 1. Both strobes are then high for GAP_CYC clocks before the next access. `mem_addr` holds the address captured at start for the whole run.
- R3: Data mode (`mode`=0). A read whose bit 7 equals bit 7 of the saved data leads to one confirming read. Completion is declared only if all 8 bits of that confirming read equal the saved data. If the confirming read differs, polling on bit 7 resumes.
- R4: Toggle mode (`mode`=1). The first read only records bit 6. Completion is declared on the first read whose bit 6 equals bit 6 of the read before it.
- R5: If completion has not been declared when TMO_CYC clocks of polling have passed since start, `timeout` rises, `done` stays 0, `busy` falls in the same cycle, and both strobes go high. A completion sampled in that last clock takes priority over the timeout.
- R6: After completion, `busy` stays 1 for GUARD_CYC more clocks. A `start` pulse is ignored whenever `busy` is 1.
- R7: `poll_count` is cleared by an accepted start and increases by one at the end of every read access, including the confirming read. It saturates at its maximum value.
- R8: `done` and `timeout` are never 1 together. Each holds its value in idle until the next accepted start clears it.
- R9: `mode`, `wr_addr` and `wr_data` are captured only when a start is accepted. Changes to them during a run have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin polling |
| mode | input | 1 | 0 = data polling on bit 7, 1 = toggle polling on bit 6 |
| wr_addr | input | AW | Address of the last byte written |
| wr_data | input | 8 | Data of the last byte written |
| mem_rdata | input | 8 | Read data from the EEPROM |
| mem_ce_n | output | 1 | Chip enable to the EEPROM, active low |
| mem_oe_n | output | 1 | Output enable to the EEPROM, active low |
| mem_we_n | output | 1 | Write enable to the EEPROM, held high |
| mem_addr | output | AW | Read address to the EEPROM |
| busy | output | 1 | A polling run or the guard interval is in progress |
| done | output | 1 | The last run completed |
| timeout | output | 1 | The last run hit the deadline |
| poll_count | output | CW | Number of reads in the current or last run |

## Verification
The strobes and `busy` change on the first clock edge after an accepted start. `mem_rdata` is sampled on the edge that ends the OE_WAIT-th low clock, and `poll_count`, `done` and `timeout` move on that same edge. `busy` falls GUARD_CYC clocks after `done` rises. A timeout lands exactly TMO_CYC edges after the start edge. The bench runs a behavioural reference that advances on every rising edge, using the same read data the design saw. It compares strobes, address and status at the following falling edge, so each result is checked in the cycle it is due and not before.

// File: rtl/epoll_pkg.sv
package epoll_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_GAP    = 2'd2,
    ST_GUARD  = 2'd3
  } epoll_state_t;

  typedef enum logic {
    MODE_DATA   = 1'b0,
    MODE_TOGGLE = 1'b1
  } epoll_mode_t;
endpackage

// File: rtl/epoll_phase_ctr.sv
// Free-running phase counter, cleared whenever the controller changes phase.
module epoll_phase_ctr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/epoll_deadline.sv
// Counts polling clocks since start; flags the last permitted clock.
module epoll_deadline #(
  parameter int LIMIT = 2500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic expire
);
  localparam int TW = $clog2(LIMIT + 1);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (run)   cnt <= cnt + 1'b1;
  end

  assign expire = run && (cnt == TW'(LIMIT - 1));
endmodule

// File: rtl/epoll_judge.sv
// Decides, per sampled read, whether the internal write has finished.
module epoll_judge
  import epoll_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        sample,
  input  epoll_mode_t mode,
  input  logic [7:0]  ref_data,
  input  logic [7:0]  rdata,
  output logic        complete
);
  logic confirm_q;   // next read is the full-byte confirmation
  logic have_q;      // a previous toggle sample exists
  logic prev_q;      // bit 6 of the previous read
  logic hit;

  always_comb begin
    if (mode == MODE_DATA) hit = confirm_q && (rdata == ref_data);
    else                   hit = have_q && (rdata[6] == prev_q);
  end

  assign complete = sample && hit;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      confirm_q <= 1'b0;
      have_q    <= 1'b0;
      prev_q    <= 1'b0;
    end else if (sample) begin
      if (mode == MODE_DATA) begin
        confirm_q <= !confirm_q && (rdata[7] == ref_data[7]);
      end else begin
        prev_q <= rdata[6];
        have_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/epoll_poller.sv
module epoll_poller
  import epoll_pkg::*;
#(
  parameter int AW        = 16,
  parameter int CW        = 16,
  parameter int OE_WAIT   = 13,
  parameter int GAP_CYC   = 2,
  parameter int GUARD_CYC = 2500,
  parameter int TMO_CYC   = 2500000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          mode,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [7:0]    mem_rdata,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [AW-1:0] mem_addr,
  output logic          busy,
  output logic          done,
  output logic          timeout,
  output logic [CW-1:0] poll_count
);
  localparam int PMAX = (OE_WAIT > GAP_CYC) ?
                        ((OE_WAIT > GUARD_CYC) ? OE_WAIT : GUARD_CYC) :
                        ((GAP_CYC > GUARD_CYC) ? GAP_CYC : GUARD_CYC);
  localparam int PW = $clog2(PMAX + 1);

  epoll_state_t  st_q, st_d;
  epoll_mode_t   mode_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic [PW-1:0] ph_cnt;
  logic          take, fin, abort;
  logic          acc_last, gap_last, guard_last;
  logic          sample, complete, expire, ph_clr;
  logic          done_q, tmo_q;
  logic [CW-1:0] cnt_q;

  assign acc_last   = (ph_cnt == PW'(OE_WAIT - 1));
  assign gap_last   = (ph_cnt == PW'(GAP_CYC - 1));
  assign guard_last = (ph_cnt == PW'(GUARD_CYC - 1));
  assign sample     = (st_q == ST_ACCESS) && acc_last;

  always_comb begin
    st_d  = st_q;
    take  = 1'b0;
    fin   = 1'b0;
    abort = 1'b0;
    case (st_q)
      ST_IDLE: if (start) begin
        st_d = ST_ACCESS;
        take = 1'b1;
      end
      ST_ACCESS: begin
        if (complete) begin
          st_d = ST_GUARD;
          fin  = 1'b1;
        end else if (expire) begin
          st_d  = ST_IDLE;
          abort = 1'b1;
        end else if (acc_last) begin
          st_d = ST_GAP;
        end
      end
      ST_GAP: begin
        if (expire) begin
          st_d  = ST_IDLE;
          abort = 1'b1;
        end else if (gap_last) begin
          st_d = ST_ACCESS;
        end
      end
      ST_GUARD: if (guard_last) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  assign ph_clr = (st_d != st_q) || (st_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      mode_q <= MODE_DATA;
      addr_q <= '0;
      data_q <= '0;
      done_q <= 1'b0;
      tmo_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      st_q <= st_d;
      if (take) begin
        mode_q <= epoll_mode_t'(mode);
        addr_q <= wr_addr;
        data_q <= wr_data;
        done_q <= 1'b0;
        tmo_q  <= 1'b0;
        cnt_q  <= '0;
      end else begin
        if (fin)   done_q <= 1'b1;
        if (abort) tmo_q  <= 1'b1;
        if (sample && (cnt_q != {CW{1'b1}})) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  epoll_phase_ctr #(.W(PW)) u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (ph_clr),
    .cnt   (ph_cnt)
  );

  epoll_deadline #(.LIMIT(TMO_CYC)) u_deadline (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (take),
    .run    ((st_q == ST_ACCESS) || (st_q == ST_GAP)),
    .expire (expire)
  );

  epoll_judge u_judge (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (take),
    .sample   (sample),
    .mode     (mode_q),
    .ref_data (data_q),
    .rdata    (mem_rdata),
    .complete (complete)
  );

  assign mem_ce_n   = (st_q != ST_ACCESS);
  assign mem_oe_n   = (st_q != ST_ACCESS);
  assign mem_we_n   = 1'b1;
  assign mem_addr   = addr_q;
  assign busy       = (st_q != ST_IDLE);
  assign done       = done_q;
  assign timeout    = tmo_q;
  assign poll_count = cnt_q;
endmodule

// File: rtl/epoll_poller_chk.sv
module epoll_poller_chk #(
  parameter int AW      = 16,
  parameter int CW      = 16,
  parameter int OE_WAIT = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_ce_n,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic [AW-1:0] mem_addr,
  input logic          busy,
  input logic          done,
  input logic          timeout,
  input logic [CW-1:0] poll_count
);
  localparam int RW = $clog2(OE_WAIT + 2);
  logic [RW-1:0] oe_run;

  always_ff @(posedge clk) begin
    if (!rst_n)        oe_run <= '0;
    else if (!mem_oe_n) oe_run <= oe_run + 1'b1;
    else               oe_run <= '0;
  end

  assert_we_high_R2: assert property (@(posedge clk) disable iff (!rst_n) mem_we_n);
  assert_read_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n) !mem_oe_n |-> !mem_ce_n);
  assert_oe_window_R2: assert property (@(posedge clk) disable iff (!rst_n) oe_run <= RW'(OE_WAIT));
  assert_idle_bus_R2: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (mem_oe_n && mem_ce_n));
  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n) (busy && $past(busy)) |-> $stable(mem_addr));
  assert_timeout_release_R5: assert property (@(posedge clk) disable iff (!rst_n) $rose(timeout) |-> (!busy && mem_oe_n));
  assert_guard_busy_R6: assert property (@(posedge clk) disable iff (!rst_n) $rose(done) |-> busy);
  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ((poll_count == $past(poll_count)) || (poll_count == $past(poll_count) + 1'b1)));
  assert_excl_R8: assert property (@(posedge clk) disable iff (!rst_n) !(done && timeout));
  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> ($stable(done) && $stable(timeout)));
endmodule

bind epoll_poller epoll_poller_chk #(.AW(AW), .CW(CW), .OE_WAIT(OE_WAIT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_ce_n   (mem_ce_n),
  .mem_oe_n   (mem_oe_n),
  .mem_we_n   (mem_we_n),
  .mem_addr   (mem_addr),
  .busy       (busy),
  .done       (done),
  .timeout    (timeout),
  .poll_count (poll_count)
);

// File: tb/epoll_poller_tb.sv
`timescale 1ns/1ps
module epoll_poller_tb;
  localparam int AW = 16, CW = 8, OEW = 3, GAP = 2, GRD = 8, TMO = 200;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, mode = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic [7:0]    mem_rdata;
  logic mem_ce_n, mem_oe_n, mem_we_n, busy, done, timeout;
  logic [AW-1:0] mem_addr;
  logic [CW-1:0] poll_count;

  always #2 clk = ~clk;

  epoll_poller #(.AW(AW), .CW(CW), .OE_WAIT(OEW), .GAP_CYC(GAP),
                 .GUARD_CYC(GRD), .TMO_CYC(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .wr_addr(wr_addr),
    .wr_data(wr_data), .mem_rdata(mem_rdata), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
    .busy(busy), .done(done), .timeout(timeout), .poll_count(poll_count));

  int checks = 0, fails = 0, cyc = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural EEPROM ----------------
  int   ee_left = 0, ee_stale = 0;
  logic [7:0] ee_byte = 8'h00;
  logic ee_tog = 1'b0, cur_busy = 1'b0, cur_bad = 1'b0, oe_prev = 1'b1;

  always @(negedge clk) begin
    if (ee_left > 0) ee_left--;
    if (!mem_oe_n && oe_prev) begin
      cur_busy = (ee_left > 0);
      if (cur_busy) ee_tog = ~ee_tog;
      cur_bad = !cur_busy && (ee_stale > 0);
      if (cur_bad) ee_stale--;
    end
    oe_prev = mem_oe_n;
  end

  assign mem_rdata = mem_oe_n ? 8'h00 :
                     cur_busy ? {~ee_byte[7], ee_tog, ee_byte[5:0]} :
                     cur_bad  ? (ee_byte ^ 8'h7F) : ee_byte;

  // ---------------- reference model ----------------
  int m_st = 0, m_k = 0, m_tmr = 0, m_cnt = 0;
  bit m_mode = 0, m_conf = 0, m_have = 0, m_prev = 0, m_done = 0, m_tmo = 0, smp = 0, hit = 0;
  logic [AW-1:0] m_addr = '0;
  logic [7:0]    m_data = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_k = 0; m_tmr = 0; m_cnt = 0; m_done = 0; m_tmo = 0;
      m_conf = 0; m_have = 0; m_prev = 0; m_addr = '0;
    end else begin
      case (m_st)
        0: if (start) begin
          m_st = 1; m_k = 0; m_tmr = 0; m_cnt = 0; m_done = 0; m_tmo = 0;
          m_mode = mode; m_addr = wr_addr; m_data = wr_data;
          m_conf = 0; m_have = 0; m_prev = 0;
        end
        1: begin
          smp = (m_k == OEW - 1);
          hit = 0;
          if (smp) begin
            if (m_cnt < 255) m_cnt++;
            if (!m_mode) begin
              hit = m_conf && (mem_rdata == m_data);
              m_conf = !m_conf && (mem_rdata[7] == m_data[7]);
            end else begin
              hit = m_have && (mem_rdata[6] == m_prev);
              m_prev = mem_rdata[6]; m_have = 1;
            end
          end
          if (hit) begin m_st = 3; m_k = 0; m_done = 1; end
          else if (m_tmr == TMO - 1) begin m_st = 0; m_tmo = 1; end
          else if (smp) begin m_st = 2; m_k = 0; end
          else m_k++;
          m_tmr++;
        end
        2: begin
          if (m_tmr == TMO - 1) begin m_st = 0; m_tmo = 1; end
          else if (m_k == GAP - 1) begin m_st = 1; m_k = 0; end
          else m_k++;
          m_tmr++;
        end
        default: if (m_k == GRD - 1) m_st = 0; else m_k++;
      endcase
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(mem_oe_n == (m_st != 1), "R2 oe_n", mem_oe_n, m_st != 1);
      chk(mem_ce_n == (m_st != 1), "R2 ce_n", mem_ce_n, m_st != 1);
      chk(mem_we_n == 1'b1, "R2 we_n", mem_we_n, 1);
      if (busy) chk(mem_addr == m_addr, "R2 addr", mem_addr, m_addr);
      chk(busy == (m_st != 0), "R6 busy", busy, m_st != 0);
      chk(done == m_done, "R8 done", done, m_done);
      chk(timeout == m_tmo, "R5 timeout", timeout, m_tmo);
      chk(int'(poll_count) == m_cnt, "R7 poll_count", poll_count, m_cnt);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog expired (all requirements) actual=%0d expected<=100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic launch(input bit md, input logic [AW-1:0] a, input logic [7:0] d,
                        input int left, input int stale);
    @(negedge clk);
    ee_byte = d; ee_left = left; ee_stale = stale;
    mode = md; wr_addr = a; wr_data = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !done && !timeout && poll_count == 0, "R1 reset status", {busy, done, timeout}, 0);
    chk(mem_ce_n && mem_oe_n && mem_we_n, "R1 reset strobes", {mem_ce_n, mem_oe_n, mem_we_n}, 7);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !timeout, "R1 after release", {busy, done, timeout}, 0);

    // R3: data polling, bit7 = 1
    launch(1'b0, 16'h1234, 8'hA5, 40, 0);
    wait_idle();
    chk(done && !timeout, "R3 data poll done", {done, timeout}, 2);

    // R3: bit7 = 0, two stale reads force a failed confirmation
    launch(1'b0, 16'h00F0, 8'h3C, 30, 2);
    wait_idle();
    chk(done && !timeout, "R3 confirm retry done", {done, timeout}, 2);
    chk(poll_count >= 4, "R3 confirm retry reads", poll_count, 4);

    // R4 + R9: toggle polling; inputs change mid-run; R6: start during guard ignored
    launch(1'b1, 16'hBEEF, 8'h11, 50, 0);
    mode = 1'b0; wr_addr = 16'h0000; wr_data = 8'hFF;
    while (!done) @(negedge clk);
    chk(busy, "R6 busy in guard", busy, 1);
    start = 1'b1; wr_addr = 16'h5555; @(negedge clk); start = 1'b0;
    chk(mem_addr == 16'hBEEF, "R9 address kept", mem_addr, 16'hBEEF);
    wait_idle();
    chk(done && !timeout, "R4 toggle done", {done, timeout}, 2);
    repeat (4) @(negedge clk);
    chk(done && !busy, "R8 done held in idle", {done, busy}, 2);

    // R4: completion already finished before the first read
    launch(1'b1, 16'h0042, 8'h40, 0, 0);
    wait_idle();
    chk(done && poll_count == 2, "R4 immediate toggle", poll_count, 2);

    // R5: toggle mode never settles
    launch(1'b1, 16'h7777, 8'h00, 5000, 0);
    wait_idle();
    chk(timeout && !done, "R5 toggle timeout", {done, timeout}, 1);

    // R5 + R8: data mode timeout, then a good run clears the flag
    launch(1'b0, 16'h0101, 8'h80, 5000, 0);
    wait_idle();
    chk(timeout && !done, "R5 data timeout", {done, timeout}, 1);
    ee_left = 0;
    launch(1'b0, 16'h0202, 8'h81, 10, 0);
    @(negedge clk);
    chk(!timeout, "R8 timeout cleared by start", timeout, 0);
    wait_idle();
    chk(done, "R8 subsequent done", done, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule